// File: doc/BRIEF.md
# Cartridge Window Bank Switcher

This block turns a CPU access to the 8 KiB cartridge window (logical `0x6000`-`0x7FFF`) into a 21-bit physical address. In cartridge emulation mode, the window always lands on one of two fixed 8 KiB physical pages: `0x36`, which starts at `0x06C000`, or `0x37`, which starts at `0x06E000`. The page register that normally maps this window is ignored in that mode. Outside emulation mode, the window passes through with the page that register supplies.

A single control bit selects single-bank or dual-bank operation. With one bank, the window always uses page `0x36`. With two banks, a write into the window does not store data. Instead, logical address bit 1 of that write picks which page later accesses use. The data value of the write plays no part.

The outputs are registered, so a result appears one clock after the access is presented. Only the window is handled here. The general mapper, the external bus and the ROM storage sit around this block.

Top module: `cart_bank_xlate`

## Requirements
- R1: During and right after synchronous reset, `win_hit` is 0 and `phys_addr` is 0, and the bank latch holds page `0x36`.
- R2: In emulation mode, a read in the window (`cpu_addr[15:13]` = 3'b011) raises `win_hit` one clock later. `phys_addr` is then `{page, cpu_addr[12:0]}`, where page is `0x36` or `0x37` and `map_page` plays no part.
- R3: With `dual_bank` = 0 in emulation mode, every window access uses page `0x36`, and window writes leave the bank latch unchanged.
- R4: With `dual_bank` = 1 in emulation mode, a window write sets the latch from `cpu_addr[1]`: 0 selects page `0x36` and 1 selects `0x37`. The new page applies from the next access on. The write's own result still reports the page that was in force before it.
- R5: In emulation mode, a window write gives `win_hit` = 0 one clock later, so it is not forwarded as a ROM store. `phys_addr` still carries the translated address.
- R6: Reads never change the bank latch.
- R7: `dual_bank` = 0 forces page `0x36` on the very access that presents it, whatever the latch holds. The latch keeps its value, and it applies again once `dual_bank` returns to 1.
- R8: Outside emulation mode, a window read or write gives `win_hit` = 1 and `phys_addr` = `{map_page, cpu_addr[12:0]}`, and it leaves the latch unchanged.
- R9: No request (`cpu_req` = 0), or an address outside the window, gives `win_hit` = 0 and `phys_addr` = 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | An access is presented this cycle |
| cpu_we | input | 1 | The access is a write |
| cpu_addr | input | 16 | Logical byte address |
| emu_en | input | 1 | Cartridge emulation mode |
| dual_bank | input | 1 | 1 = two-bank switching, 0 = single bank |
| map_page | input | 8 | Page normally mapped to the window |
| phys_addr | output | 21 | Registered physical address |
| win_hit | output | 1 | Registered: the access reaches cartridge storage |

## Verification
The two functions that can share a cycle are the bank latch update caused by a window write and the translation of that same write. A third case is a write followed directly by a read, where the read must already see the new page. The bench drives back-to-back write/read pairs with both values of address bit 1, and it toggles `dual_bank` during the stream. A reference model updates its latch only after it has computed the expected result for the current access, so an early latch update or a missing forced page shows up as a wrong page in `phys_addr[20:13]`.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int                  LA_W     = 16;
  localparam int                  OFF_W    = 13;
  localparam int                  PAGE_W   = 8;
  localparam int                  TAG_W    = LA_W - OFF_W;
  localparam logic [TAG_W-1:0]    WIN_TAG  = 3'b011;
  localparam logic [PAGE_W-1:0]   PAGE_LO  = 8'h36;
  localparam logic [PAGE_W-1:0]   PAGE_HI  = 8'h37;
endpackage

// File: rtl/cbx_win_decode.sv
module cbx_win_decode #(
  parameter int LA_W  = 16,
  parameter int OFF_W = 13,
  parameter logic [LA_W-OFF_W-1:0] WIN_TAG = 3'b011
) (
  input  logic [LA_W-1:0]  addr,
  output logic             in_win,
  output logic [OFF_W-1:0] offset
);
  assign in_win = (addr[LA_W-1:OFF_W] == WIN_TAG);
  assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/cbx_bank_latch.sv
module cbx_bank_latch (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_in,
  output logic sel_q
);
  always_ff @(posedge clk) begin
    if (rst)       sel_q <= 1'b0;
    else if (load) sel_q <= sel_in;
  end
endmodule

// File: rtl/cbx_page_sel.sv
module cbx_page_sel #(
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE_LO = 8'h36,
  parameter logic [PAGE_W-1:0] PAGE_HI = 8'h37
) (
  input  logic              emu_en,
  input  logic              dual_bank,
  input  logic              sel_q,
  input  logic [PAGE_W-1:0] map_page,
  output logic [PAGE_W-1:0] page
);
  always_comb begin
    if (!emu_en)                   page = map_page;
    else if (dual_bank && sel_q)   page = PAGE_HI;
    else                           page = PAGE_LO;
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate #(
  parameter int LA_W   = cbx_pkg::LA_W,
  parameter int OFF_W  = cbx_pkg::OFF_W,
  parameter int PAGE_W = cbx_pkg::PAGE_W,
  parameter logic [LA_W-OFF_W-1:0] WIN_TAG = cbx_pkg::WIN_TAG,
  parameter logic [PAGE_W-1:0]     PAGE_LO = cbx_pkg::PAGE_LO,
  parameter logic [PAGE_W-1:0]     PAGE_HI = cbx_pkg::PAGE_HI
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [LA_W-1:0]         cpu_addr,
  input  logic                    emu_en,
  input  logic                    dual_bank,
  input  logic [PAGE_W-1:0]       map_page,
  output logic [PAGE_W+OFF_W-1:0] phys_addr,
  output logic                    win_hit
);
  localparam int PA_W = PAGE_W + OFF_W;

  logic              in_win;
  logic [OFF_W-1:0]  offset;
  logic              sel_q;
  logic              bank_load;
  logic [PAGE_W-1:0] page;
  logic              hit_d;
  logic [PA_W-1:0]   addr_d;

  cbx_win_decode #(.LA_W(LA_W), .OFF_W(OFF_W), .WIN_TAG(WIN_TAG)) u_dec (
    .addr(cpu_addr), .in_win(in_win), .offset(offset)
  );

  assign bank_load = cpu_req && cpu_we && emu_en && dual_bank && in_win;

  cbx_bank_latch u_latch (
    .clk(clk), .rst(rst), .load(bank_load), .sel_in(cpu_addr[1]), .sel_q(sel_q)
  );

  cbx_page_sel #(.PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI)) u_sel (
    .emu_en(emu_en), .dual_bank(dual_bank), .sel_q(sel_q),
    .map_page(map_page), .page(page)
  );

  always_comb begin
    hit_d  = 1'b0;
    addr_d = '0;
    if (cpu_req && in_win) begin
      addr_d = {page, offset};
      hit_d  = !(emu_en && cpu_we);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      win_hit   <= 1'b0;
    end else begin
      phys_addr <= addr_d;
      win_hit   <= hit_d;
    end
  end
endmodule

// File: rtl/cbx_checker.sv
module cbx_checker #(
  parameter int LA_W = 16, parameter int OFF_W = 13, parameter int PAGE_W = 8,
  parameter logic [LA_W-OFF_W-1:0] WIN_TAG = 3'b011,
  parameter logic [PAGE_W-1:0] PAGE_LO = 8'h36,
  parameter logic [PAGE_W-1:0] PAGE_HI = 8'h37
) (
  input logic clk, input logic rst, input logic cpu_req, input logic cpu_we,
  input logic [LA_W-1:0] cpu_addr, input logic emu_en, input logic dual_bank,
  input logic [PAGE_W-1:0] map_page, input logic [PAGE_W+OFF_W-1:0] phys_addr,
  input logic win_hit
);
  logic [1:0] age;
  logic       was_rst;
  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  wire win    = cpu_addr[LA_W-1:OFF_W] == WIN_TAG;
  wire [PAGE_W-1:0] pg = phys_addr[PAGE_W+OFF_W-1:OFF_W];

  always @(negedge clk) begin
    if (was_rst === 1'b1)
      a_r1_reset_quiet: assert (win_hit == 1'b0 && phys_addr == '0);
  end

  a_r2_emu_read_fixed: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && emu_en && win) |=> (win_hit && (pg == PAGE_LO || pg == PAGE_HI)));

  a_r3_single_lo: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && emu_en && !dual_bank && win) |=> (pg == PAGE_LO));

  a_r4_bank_follow: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(cpu_req && cpu_we && emu_en && dual_bank && win)
     && cpu_req && emu_en && dual_bank && win)
    |=> (pg == ($past(cpu_addr[1], 2) ? PAGE_HI : PAGE_LO)));

  a_r5_emu_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && emu_en && win) |=> !win_hit);

  a_r8_pass_through: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !emu_en && win) |=> (win_hit && pg == $past(map_page)));

  a_r9_outside_idle: assert property (@(posedge clk) disable iff (rst)
    !(cpu_req && win) |=> (!win_hit && phys_addr == '0));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && win) |=> (phys_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0])));
endmodule

bind cart_bank_xlate cbx_checker #(
  .LA_W(LA_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
  .WIN_TAG(WIN_TAG), .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI)
) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .emu_en(emu_en), .dual_bank(dual_bank), .map_page(map_page),
  .phys_addr(phys_addr), .win_hit(win_hit)
);

// File: tb/cart_bank_xlate_test.sv
module cart_bank_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, emu_en = 1'b0, dual_bank = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  map_page = '0;
  logic [20:0] phys_addr;
  logic        win_hit;

  int total = 0, bad = 0;
  logic m_hi = 1'b0;   // model latch: 1 = page 0x37
  bit   done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  cart_bank_xlate uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .emu_en(emu_en), .dual_bank(dual_bank), .map_page(map_page),
    .phys_addr(phys_addr), .win_hit(win_hit)
  );

  function automatic string tag_of(input logic r, input logic w, input logic e,
                                   input logic d, input logic [15:0] a);
    if (!r || a[15:13] != 3'b011) return "R9";
    if (!e)                       return "R8";
    if (w)                        return d ? "R4/R5" : "R3/R5";
    return d ? "R2/R6/R7" : "R3/R7";
  endfunction

  task automatic check(input string tag, input logic [20:0] ea, input logic eh);
    total++;
    if (phys_addr !== ea || win_hit !== eh) begin
      bad++;
      $display("FAIL %s: addr=%h hit=%b expected addr=%h hit=%b", tag, phys_addr, win_hit, ea, eh);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic e, input logic d,
                      input logic [15:0] a, input logic [7:0] mp);
    logic [20:0] ea;
    logic        eh;
    logic [7:0]  pg;
    string       t;
    @(negedge clk);
    cpu_req = r; cpu_we = w; emu_en = e; dual_bank = d; cpu_addr = a; map_page = mp;
    t = tag_of(r, w, e, d, a);
    ea = '0; eh = 1'b0;
    if (r && a[15:13] == 3'b011) begin
      if (!e) pg = mp;
      else    pg = (d && m_hi) ? 8'h37 : 8'h36;
      ea = {pg, a[12:0]};
      eh = !(e && w);
    end
    if (r && w && e && d && a[15:13] == 3'b011) m_hi = a[1];
    @(posedge clk); #1;
    check(t, ea, eh);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1; check("R1", '0, 1'b0);
    @(negedge clk); rst = 1'b0;
    // R1: latch starts on 0x36
    step(1, 0, 1, 1, 16'h6abc, 8'h55);
    // R4: select high page, own result still shows old page
    step(1, 1, 1, 1, 16'h6002, 8'h00);
    step(1, 0, 1, 1, 16'h7ff0, 8'h11);
    // R6: reads do not move it
    step(1, 0, 1, 1, 16'h6000, 8'h22);
    // R7: clear mode forces 0x36 at once, latch retained
    step(1, 0, 1, 0, 16'h6123, 8'h22);
    // R3: single-bank write leaves latch
    step(1, 1, 1, 0, 16'h6000, 8'h00);
    step(1, 0, 1, 1, 16'h6124, 8'h00);
    // R4: back to low page with n*4 address
    step(1, 1, 1, 1, 16'h6ff8, 8'h00);
    step(1, 0, 1, 1, 16'h6ff8, 8'h00);
    // R8: pass-through, writes do not change latch
    step(1, 1, 0, 1, 16'h6002, 8'hc4);
    step(1, 0, 0, 1, 16'h7001, 8'hee);
    step(1, 0, 1, 1, 16'h6010, 8'h00);
    // R9: outside and idle
    step(1, 0, 1, 1, 16'h8000, 8'h36);
    step(1, 1, 1, 1, 16'h5ffe, 8'h36);
    step(0, 1, 1, 1, 16'h6002, 8'h36);
    step(1, 0, 1, 1, 16'h6000, 8'h36);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a = $urandom;
      if ($urandom_range(0, 3) != 0) a[15:13] = 3'b011;
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
           $urandom_range(0, 3) != 0, a, 8'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule